// File: doc/BRIEF.md
# Segment Descriptor Cache Loader

This block keeps the hidden descriptor cache for six segment registers. Each entry holds a 32-bit base, a 32-bit effective limit, an 8-bit access byte and a default operand size bit. The cached fields of every entry are always visible at the outputs, so address generation can read them without a table lookup.

A load request names a segment, gives a 16-bit selector, and says whether the machine is in real or protected mode. A far-jump flag is also carried. In protected mode the request also carries the 64-bit descriptor that was already fetched.

In real mode only the base changes, and the limit and access rights left by earlier loads stay in place. The one exception is a far jump into the code segment, which forces that entry's access byte to the real-mode value 93h. In protected mode the descriptor is checked first. If it passes, it replaces the whole entry. If it fails, the entry is left untouched and a one-cycle fault pulse reports the exception vector.

Top module: `seg_cache_loader`

## Requirements
- R1: After reset every entry has base 0, limit 0000FFFFh, access byte 93h and size bit 0, and `fault_valid` is 0.
- R2: A real-mode load (`ld_prot`=0) of segment index 0 to 5 sets that entry's base to the selector times 16. The new value is visible after the clock edge that accepts the request.
- R3: A real-mode load keeps the entry's limit, access byte and size bit. This covers a load of index 1 to 5 and a load of index 0 without `ld_farjmp`.
- R4: A real-mode load of index 0 (code segment) with `ld_farjmp`=1 sets its access byte to 93h and keeps its limit and size bit. On any other index, `ld_farjmp` has no effect.
- R5: An accepted protected-mode load replaces all fields of the entry from the descriptor, with no old value kept:
  - base = {desc[63:56], desc[39:16]};
  - access = desc[47:40];
  - size bit = desc[54].
- R6: The stored limit is built from the 20-bit raw limit {desc[51:48], desc[15:0]}. When desc[55]=1 it is the raw limit shifted left by 12 with the low 12 bits set to ones. When desc[55]=0 it is the raw limit zero-extended.
- R7: A protected-mode load whose class bit desc[44] is 0 (system descriptor) faults with vector 13. This check comes first.
- R8: If R7 passes, a protected-mode load faults with vector 13 in two cases:
  - index 0 is loaded with desc[43]=0 (not executable);
  - index 1 to 5 is loaded with desc[43]=1 (executable).
- R9: If R7 and R8 pass, a protected-mode load with present bit desc[47]=0 faults with vector 11.
- R10: A faulting load changes no entry. `fault_valid` is 1 for exactly the one cycle after the accepting edge, with the vector on `fault_vec`, and is 0 in any cycle that does not follow a faulting load.
- R11: A request with index 6 or 7 changes no entry and raises no fault, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | Load request this cycle |
| ld_seg | input | 3 | Segment index (0 code, 1 stack, 2..5 data) |
| ld_sel | input | 16 | Selector value |
| ld_prot | input | 1 | 1 = protected mode, 0 = real mode |
| ld_farjmp | input | 1 | Load comes from a far jump |
| ld_desc | input | 64 | Fetched descriptor (protected mode) |
| seg_base | output | 192 | Bases, entry i at bits [32i+31:32i] |
| seg_limit | output | 192 | Effective limits, entry i at bits [32i+31:32i] |
| seg_access | output | 48 | Access bytes, entry i at bits [8i+7:8i] |
| seg_dsize | output | 6 | Default size bit, entry i at bit i |
| fault_valid | output | 1 | One-cycle fault pulse |
| fault_vec | output | 8 | Exception vector while fault_valid is 1 |

## Verification
The bench first places a protected-mode descriptor with a page-granular 4 GB limit and a read-only access byte into a data entry. It then reloads that entry in real mode, which separates a design that keeps the old limit and access byte from one that resets them.

Code-segment reloads are tried with and without the far-jump flag, and the flag is also set on data indices. This shows that only the code entry with the flag set returns to 93h, while its limit and size bit survive.

Faulting descriptors combine a missing present bit with a system class, which exposes the check order. Back-to-back faults followed by an idle cycle show that the pulse lasts one cycle. Out-of-range indices and every-index sweeps confirm that the right entry, and only that entry, changes.

// File: rtl/segc_pkg.sv
// Package: shared types and constants for the segment descriptor cache.
// Assumes a 32-bit linear base and limit and a 64-bit descriptor in the
// conventional split-field layout.
package segc_pkg;

    localparam int ADDR_W = 32;
    localparam int ACC_W  = 8;
    localparam int DESC_W = 64;

    // Descriptor field positions
    localparam int D_LIM_LO_MSB = 15;
    localparam int D_BASE_LO_LSB = 16;
    localparam int D_BASE_LO_MSB = 39;
    localparam int D_ACC_LSB    = 40;
    localparam int D_ACC_MSB    = 47;
    localparam int D_LIM_HI_LSB = 48;
    localparam int D_LIM_HI_MSB = 51;
    localparam int D_SIZE_BIT   = 54;
    localparam int D_GRAN_BIT   = 55;
    localparam int D_BASE_HI_LSB = 56;
    localparam int D_BASE_HI_MSB = 63;

    // Access byte bit positions
    localparam int A_PRESENT = 7;
    localparam int A_CLASS   = 4;
    localparam int A_EXEC    = 3;

    localparam logic [ACC_W-1:0]  RM_ACCESS = 8'h93;
    localparam logic [ADDR_W-1:0] RM_LIMIT  = 32'h0000_FFFF;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
        logic [ACC_W-1:0]  access;
        logic              dsize;
    } seg_ent_t;

    typedef struct packed {
        logic     present;
        logic     code_data;
        logic     exec;
        seg_ent_t ent;
    } desc_info_t;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_GP   = 2'd1,
        FLT_NP   = 2'd2
    } flt_kind_t;

    localparam seg_ent_t RST_ENT = '{
        base:   '0,
        limit:  RM_LIMIT,
        access: RM_ACCESS,
        dsize:  1'b0
    };

endpackage

// File: rtl/segc_desc_decode.sv
// Module: segc_desc_decode
// Unpacks a 64-bit descriptor into cache-entry form and applies the
// granularity scaling to the limit. Purely combinational.
// Assumes the descriptor has already been fetched and is stable.
module segc_desc_decode
    import segc_pkg::*;
(
    input  logic [DESC_W-1:0] desc_i,
    output desc_info_t        info_o
);

    logic [19:0] raw_lim;
    logic        unused_bits;

    // Spare descriptor bits carry no meaning for the cache
    assign unused_bits = ^desc_i[D_SIZE_BIT-1:D_LIM_HI_MSB+1];

    // Field extraction and limit scaling
    always_comb begin
        raw_lim = {desc_i[D_LIM_HI_MSB:D_LIM_HI_LSB], desc_i[D_LIM_LO_MSB:0]};
        info_o.ent.base = {desc_i[D_BASE_HI_MSB:D_BASE_HI_LSB],
                           desc_i[D_BASE_LO_MSB:D_BASE_LO_LSB]};
        if (desc_i[D_GRAN_BIT]) begin
            info_o.ent.limit = {raw_lim, 12'hFFF};
        end else begin
            info_o.ent.limit = {12'h000, raw_lim};
        end
        info_o.ent.access = desc_i[D_ACC_MSB:D_ACC_LSB];
        info_o.ent.dsize  = desc_i[D_SIZE_BIT];
        info_o.present    = desc_i[D_ACC_LSB + A_PRESENT];
        info_o.code_data  = desc_i[D_ACC_LSB + A_CLASS];
        info_o.exec       = desc_i[D_ACC_LSB + A_EXEC];
    end

endmodule

// File: rtl/segc_load_rules.sv
// Module: segc_load_rules
// Decides, for one load request, the next value of the addressed entry,
// whether it is written and which fault (if any) is raised.
// Assumes old_ent_i is the current content of the addressed entry.
module segc_load_rules
    import segc_pkg::*;
#(
    parameter int NUM_SEG = 6,
    parameter int SEG_W   = 3,
    parameter int SEL_W   = 16,
    parameter int CS_IDX  = 0
) (
    input  logic             req_valid_i,
    input  logic [SEG_W-1:0] seg_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             prot_i,
    input  logic             farjmp_i,
    input  desc_info_t       info_i,
    input  seg_ent_t         old_ent_i,
    output logic             wr_en_o,
    output seg_ent_t         new_ent_o,
    output flt_kind_t        flt_o
);

    localparam logic [SEG_W:0]   NUM_CODE = NUM_SEG[SEG_W:0];
    localparam logic [SEG_W-1:0] CS_CODE  = CS_IDX[SEG_W-1:0];
    localparam int               PAD_W    = ADDR_W - SEL_W - 4;

    logic in_range;
    logic is_cs;
    logic [ADDR_W-1:0] rm_base;

    // Index classification and real-mode base
    always_comb begin
        in_range = ({1'b0, seg_i} < NUM_CODE);
        is_cs    = (seg_i == CS_CODE);
        rm_base  = {{PAD_W{1'b0}}, sel_i, 4'h0};
    end

    // Mode-specific update and protection checks
    always_comb begin
        new_ent_o = old_ent_i;
        wr_en_o   = 1'b0;
        flt_o     = FLT_NONE;
        if (req_valid_i && in_range) begin
            if (!prot_i) begin
                new_ent_o.base = rm_base;
                if (is_cs && farjmp_i) begin
                    new_ent_o.access = RM_ACCESS;
                end
                wr_en_o = 1'b1;
            end else if (!info_i.code_data) begin
                flt_o = FLT_GP;
            end else if (info_i.exec != is_cs) begin
                flt_o = FLT_GP;
            end else if (!info_i.present) begin
                flt_o = FLT_NP;
            end else begin
                new_ent_o = info_i.ent;
                wr_en_o   = 1'b1;
            end
        end
    end

endmodule

// File: rtl/segc_entry_reg.sv
// Module: segc_entry_reg
// One cache entry register with write enable and reset to the
// real-mode data segment value.
module segc_entry_reg
    import segc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en_i,
    input  seg_ent_t d_i,
    output seg_ent_t q_o
);

    // Hold or update the entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= RST_ENT;
        end else if (wr_en_i) begin
            q_o <= d_i;
        end
    end

endmodule

// File: rtl/seg_cache_loader.sv
// Module: seg_cache_loader
// Top of the segment descriptor cache. Holds NUM_SEG entries, applies one
// load request per cycle, and reports protection faults as a registered
// one-cycle pulse. Assumes descriptors are fetched by the requester.
module seg_cache_loader
    import segc_pkg::*;
#(
    parameter int NUM_SEG = 6,
    parameter int SEG_W   = 3,
    parameter int SEL_W   = 16,
    parameter int VEC_W   = 8,
    parameter int CS_IDX  = 0,
    parameter int NP_VEC  = 11,
    parameter int GP_VEC  = 13
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ld_valid,
    input  logic [SEG_W-1:0]          ld_seg,
    input  logic [SEL_W-1:0]          ld_sel,
    input  logic                      ld_prot,
    input  logic                      ld_farjmp,
    input  logic [DESC_W-1:0]         ld_desc,
    output logic [NUM_SEG*ADDR_W-1:0] seg_base,
    output logic [NUM_SEG*ADDR_W-1:0] seg_limit,
    output logic [NUM_SEG*ACC_W-1:0]  seg_access,
    output logic [NUM_SEG-1:0]        seg_dsize,
    output logic                      fault_valid,
    output logic [VEC_W-1:0]          fault_vec
);

    localparam logic [VEC_W-1:0] NP_CODE = NP_VEC[VEC_W-1:0];
    localparam logic [VEC_W-1:0] GP_CODE = GP_VEC[VEC_W-1:0];

    seg_ent_t            ents [NUM_SEG];
    seg_ent_t            old_ent;
    seg_ent_t            new_ent;
    desc_info_t          info;
    flt_kind_t           flt;
    logic                wr_en;
    logic [NUM_SEG-1:0]  wr_sel;

    // Descriptor unpacking
    segc_desc_decode u_dec (
        .desc_i (ld_desc),
        .info_o (info)
    );

    // Read the addressed entry and steer the write enable
    always_comb begin
        old_ent = RST_ENT;
        wr_sel  = '0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (ld_seg == i[SEG_W-1:0]) begin
                old_ent   = ents[i];
                wr_sel[i] = wr_en;
            end
        end
    end

    // Load rules and protection checks
    segc_load_rules #(
        .NUM_SEG (NUM_SEG),
        .SEG_W   (SEG_W),
        .SEL_W   (SEL_W),
        .CS_IDX  (CS_IDX)
    ) u_rules (
        .req_valid_i (ld_valid),
        .seg_i       (ld_seg),
        .sel_i       (ld_sel),
        .prot_i      (ld_prot),
        .farjmp_i    (ld_farjmp),
        .info_i      (info),
        .old_ent_i   (old_ent),
        .wr_en_o     (wr_en),
        .new_ent_o   (new_ent),
        .flt_o       (flt)
    );

    // Entry storage, one register per segment
    for (genvar g = 0; g < NUM_SEG; g++) begin : g_ent
        segc_entry_reg u_ent (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en_i (wr_sel[g]),
            .d_i     (new_ent),
            .q_o     (ents[g])
        );
        assign seg_base[g*ADDR_W +: ADDR_W]  = ents[g].base;
        assign seg_limit[g*ADDR_W +: ADDR_W] = ents[g].limit;
        assign seg_access[g*ACC_W +: ACC_W]  = ents[g].access;
        assign seg_dsize[g]                  = ents[g].dsize;
    end

    // Registered one-cycle fault report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_valid <= 1'b0;
            fault_vec   <= '0;
        end else begin
            fault_valid <= (flt != FLT_NONE);
            case (flt)
                FLT_NP:  fault_vec <= NP_CODE;
                FLT_GP:  fault_vec <= GP_CODE;
                default: fault_vec <= '0;
            endcase
        end
    end

endmodule

// File: rtl/seg_cache_loader_chk.sv
// Module: seg_cache_loader_chk
// Protocol checker for seg_cache_loader at its default parameters
// (six entries, index 0 is the code segment, index 2 a data segment).
module seg_cache_loader_chk (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_valid,
    input  logic [2:0]   ld_seg,
    input  logic [15:0]  ld_sel,
    input  logic         ld_prot,
    input  logic         ld_farjmp,
    input  logic [63:0]  ld_desc,
    input  logic [191:0] seg_base,
    input  logic [191:0] seg_limit,
    input  logic [47:0]  seg_access,
    input  logic [5:0]   seg_dsize,
    input  logic         fault_valid,
    input  logic [7:0]   fault_vec
);

    logic legal_prot;
    logic req_in;

    // Request classification used by several properties
    always_comb begin
        req_in     = ld_valid && (ld_seg < 3'd6);
        legal_prot = req_in && ld_prot && ld_desc[44] && ld_desc[47] &&
                     (ld_desc[43] == (ld_seg == 3'd0));
    end

    // R2, R3: real-mode data load sets base and keeps limit and access
    p_rm_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid && !ld_prot && ld_seg == 3'd2 |=>
        seg_base[95:64] == {12'h000, $past(ld_sel), 4'h0} &&
        $stable(seg_limit[95:64]) && $stable(seg_access[23:16]));

    // R4: far jump into the code entry restores 93h, keeps limit and size
    p_farjmp_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid && !ld_prot && ld_farjmp && ld_seg == 3'd0 |=>
        seg_access[7:0] == 8'h93 && $stable(seg_limit[31:0]) &&
        $stable(seg_dsize[0]));

    // R5: a legal protected load raises no fault
    p_legal_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
        legal_prot |=> !fault_valid);

    // R7: system descriptor gives vector 13
    p_sys_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_in && ld_prot && !ld_desc[44] |=>
        fault_valid && fault_vec == 8'd13);

    // R9: not-present after passing class and type checks gives vector 11
    p_np_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_in && ld_prot && ld_desc[44] && !ld_desc[47] &&
        (ld_desc[43] == (ld_seg == 3'd0)) |=>
        fault_valid && fault_vec == 8'd11);

    // R10: a fault pulse comes with no entry change
    p_fault_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> $stable(seg_base) && $stable(seg_limit) &&
        $stable(seg_access) && $stable(seg_dsize));

    // R10: no request, no fault in the next cycle
    p_fault_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |=> !fault_valid);

    // R11: out-of-range index changes nothing
    p_bad_index_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid && ld_seg >= 3'd6 |=> !fault_valid &&
        $stable(seg_base) && $stable(seg_limit) &&
        $stable(seg_access) && $stable(seg_dsize));

endmodule

bind seg_cache_loader seg_cache_loader_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_valid    (ld_valid),
    .ld_seg      (ld_seg),
    .ld_sel      (ld_sel),
    .ld_prot     (ld_prot),
    .ld_farjmp   (ld_farjmp),
    .ld_desc     (ld_desc),
    .seg_base    (seg_base),
    .seg_limit   (seg_limit),
    .seg_access  (seg_access),
    .seg_dsize   (seg_dsize),
    .fault_valid (fault_valid),
    .fault_vec   (fault_vec)
);

// File: tb/seg_cache_loader_test.sv
// Bench: scoreboard for seg_cache_loader. The driver computes the expected
// entries and fault from the requirements and queues them; the monitor
// compares them one cycle after each accepted request.
module seg_cache_loader_test;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [191:0] b;
        logic [191:0] l;
        logic [47:0]  a;
        logic [5:0]   d;
        logic         f;
        logic [7:0]   v;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ld_valid = 1'b0;
    logic [2:0]   ld_seg = '0;
    logic [15:0]  ld_sel = '0;
    logic         ld_prot = 1'b0;
    logic         ld_farjmp = 1'b0;
    logic [63:0]  ld_desc = '0;
    logic [191:0] seg_base;
    logic [191:0] seg_limit;
    logic [47:0]  seg_access;
    logic [5:0]   seg_dsize;
    logic         fault_valid;
    logic [7:0]   fault_vec;

    int total = 0;
    int bad = 0;

    logic [31:0] m_base [6];
    logic [31:0] m_lim  [6];
    logic [7:0]  m_acc  [6];
    logic        m_dsz  [6];

    exp_t  q_exp [$];
    string q_tag [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_cache_loader uut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_seg(ld_seg),
        .ld_sel(ld_sel), .ld_prot(ld_prot), .ld_farjmp(ld_farjmp),
        .ld_desc(ld_desc), .seg_base(seg_base), .seg_limit(seg_limit),
        .seg_access(seg_access), .seg_dsize(seg_dsize),
        .fault_valid(fault_valid), .fault_vec(fault_vec)
    );

    function automatic logic [63:0] mk_desc(input logic [31:0] base,
        input logic [19:0] lim, input logic [7:0] acc, input logic g,
        input logic d);
        logic [63:0] r;
        r = '0;
        r[15:0]  = lim[15:0];
        r[39:16] = base[23:0];
        r[47:40] = acc;
        r[51:48] = lim[19:16];
        r[54]    = d;
        r[55]    = g;
        r[63:56] = base[31:24];
        return r;
    endfunction

    function automatic exp_t snap(input logic f, input logic [7:0] v);
        exp_t e;
        for (int i = 0; i < 6; i++) begin
            e.b[i*32 +: 32] = m_base[i];
            e.l[i*32 +: 32] = m_lim[i];
            e.a[i*8 +: 8]   = m_acc[i];
            e.d[i]          = m_dsz[i];
        end
        e.f = f;
        e.v = v;
        return e;
    endfunction

    task automatic check(input string tag, input logic [447:0] act,
        input logic [447:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Driver: model the requested load, queue the expectation, drive it
    task automatic do_load(input logic [2:0] seg, input logic [15:0] sel,
        input logic prot, input logic fj, input logic [63:0] desc,
        input string tag);
        logic       f;
        logic [7:0] v;
        logic [7:0] acc;
        f = 1'b0;
        v = 8'd0;
        acc = desc[47:40];
        if (seg < 3'd6) begin
            if (!prot) begin
                m_base[seg] = {12'h000, sel, 4'h0};
                if (seg == 3'd0 && fj) m_acc[seg] = 8'h93;
            end else if (!acc[4]) begin
                f = 1'b1; v = 8'd13;
            end else if (acc[3] != (seg == 3'd0)) begin
                f = 1'b1; v = 8'd13;
            end else if (!acc[7]) begin
                f = 1'b1; v = 8'd11;
            end else begin
                m_base[seg] = {desc[63:56], desc[39:16]};
                m_lim[seg]  = desc[55] ? {desc[51:48], desc[15:0], 12'hFFF}
                                       : {12'h000, desc[51:48], desc[15:0]};
                m_acc[seg]  = acc;
                m_dsz[seg]  = desc[54];
            end
        end
        q_exp.push_back(snap(f, v));
        q_tag.push_back(tag);
        ld_valid  = 1'b1;
        ld_seg    = seg;
        ld_sel    = sel;
        ld_prot   = prot;
        ld_farjmp = fj;
        ld_desc   = desc;
        @(posedge clk);
        @(negedge clk);
        ld_valid  = 1'b0;
    endtask

    task automatic idle_check(input string tag);
        @(posedge clk);
        @(negedge clk);
        check(tag, {439'd0, fault_valid, fault_vec}, 448'd0);
    endtask

    // Monitor: compare one cycle after each accepted request
    initial begin
        forever begin
            @(posedge clk);
            if (ld_valid && rst_n) begin
                exp_t  e;
                string t;
                @(negedge clk);
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                check({t, " entries"},
                      {seg_base, seg_limit, seg_access, seg_dsize, 9'd0},
                      {e.b, e.l, e.a, e.d, 9'd0});
                check({t, " fault"}, {439'd0, fault_valid, fault_vec},
                      {439'd0, e.f, e.f ? e.v : 8'd0});
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Stimulus
    initial begin
        for (int i = 0; i < 6; i++) begin
            m_base[i] = '0; m_lim[i] = 32'h0000FFFF;
            m_acc[i] = 8'h93; m_dsz[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 reset", {seg_base, seg_limit, seg_access, seg_dsize,
              fault_valid, fault_vec},
              {snap(1'b0, 8'd0)});

        // R2, R3: simple real-mode data load
        do_load(3'd2, 16'h1234, 1'b0, 1'b0, '0, "R2 rm DS base");
        // R5, R6: 4 GB read-only data via page granularity
        do_load(3'd2, 16'h0010, 1'b1, 1'b0,
                mk_desc(32'h0040_0000, 20'hFFFFF, 8'h91, 1'b1, 1'b0),
                "R6 pm DS gran");
        // R3: real-mode reload keeps 4 GB limit and 91h access
        do_load(3'd2, 16'h0020, 1'b0, 1'b0, '0, "R3 rm DS keep");
        // R5: protected code load with 32-bit size
        do_load(3'd0, 16'h0008, 1'b1, 1'b0,
                mk_desc(32'h1200_3400, 20'h0FFFF, 8'h9B, 1'b0, 1'b1),
                "R5 pm CS");
        // R3: real-mode code load without far jump keeps 9Bh
        do_load(3'd0, 16'h2000, 1'b0, 1'b0, '0, "R3 rm CS no jump");
        // R4: far jump restores 93h, keeps limit and size
        do_load(3'd0, 16'hF000, 1'b0, 1'b1, '0, "R4 rm CS far jump");
        // R4: far-jump flag on a data index has no effect on access
        do_load(3'd2, 16'h0030, 1'b0, 1'b1, '0, "R4 fj on DS");
        // R6: byte granular stack limit
        do_load(3'd1, 16'h0018, 1'b1, 1'b0,
                mk_desc(32'hABCD_0000, 20'h12345, 8'h93, 1'b0, 1'b0),
                "R6 pm SS byte gran");
        // R7: system descriptor into data index
        do_load(3'd3, 16'h0028, 1'b1, 1'b0,
                mk_desc(32'h0, 20'hFFFF, 8'h82, 1'b0, 1'b0), "R7 sys ES");
        // R7 over R9: system and not present together
        do_load(3'd4, 16'h0028, 1'b1, 1'b0,
                mk_desc(32'h0, 20'hFFFF, 8'h02, 1'b0, 1'b0), "R7 prio");
        // R8: data descriptor into code index
        do_load(3'd0, 16'h0030, 1'b1, 1'b0,
                mk_desc(32'h5000, 20'hFFFF, 8'h93, 1'b0, 1'b0), "R8 CS data");
        // R8: executable descriptor into data index
        do_load(3'd4, 16'h0038, 1'b1, 1'b0,
                mk_desc(32'h6000, 20'hFFFF, 8'h9A, 1'b0, 1'b0), "R8 FS exec");
        // R9: not-present data descriptor
        do_load(3'd5, 16'h0040, 1'b1, 1'b0,
                mk_desc(32'h7000, 20'hFFFF, 8'h13, 1'b0, 1'b0), "R9 GS np");
        // R10: fault pulse ends when no request follows
        idle_check("R10 pulse end");
        // R11: out-of-range indices in both modes
        do_load(3'd6, 16'h0050, 1'b1, 1'b0,
                mk_desc(32'h8000, 20'hFFFF, 8'h02, 1'b0, 1'b0), "R11 idx6");
        do_load(3'd7, 16'h0058, 1'b0, 1'b1, '0, "R11 idx7");
        // R2: every index in real mode
        for (int i = 0; i < 6; i++) begin
            do_load(i[2:0], 16'h0100 + 16'(i), 1'b0, 1'b0, '0, "R2 sweep");
        end
        idle_check("R10 idle");
        repeat (2) @(posedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule